// File: doc/BRIEF.md
# Monitor Byte Channel Handshake Controller

This block runs the flow control for a full-duplex monitor byte channel carried inside a repeating TDM frame. In every frame the channel carries one data byte and two active-low handshake bits: the sender's transmit flag (MX) and the receiver's acknowledge flag (MR). A frame serializer outside this block pulses `frameTick` once per frame. On that pulse the block samples the far end's byte and handshake bits from the frame that just ended, and it updates its own byte and bits for the next frame. Transfers therefore line up with the frame, while the pace of the data is set by the handshake.

The transmit half takes a byte from a valid/ready interface. It waits until the transmit direction has been quiet for a configurable number of frames, then drives the byte with MX low. It keeps driving both until the far end acknowledges. The receive half watches for a falling edge on the far end's MX. On that edge it captures the byte, pulses `rxValid`, and holds its own MR low for exactly one frame as the acknowledge. Both halves run independently. A transmit abort releases MX at the next frame boundary.

Top module: `mon_handshake`

## Requirements
- R1: After reset `lineTxMx`=1, `lineTxMr`=1, `lineTxByte`=8'hFF, `rxByte`=8'hFF, `rxValid`=0 and `txReady`=1.
- R2: `lineTxMx`, `lineTxMr` and `lineTxByte` change only on the clock edge where `frameTick` is 1. Stimulus applied between ticks does not move them.
- R3: A pending byte is driven (`lineTxByte`=byte, `lineTxMx`=0) at a tick only when the previous IDLE_FRAMES (default 2) consecutive ticks each sampled `lineTxMx`=1 and `lineRxMr`=1. A tick that samples `lineRxMr`=0 restarts this count.
- R4: While sending, the byte and `lineTxMx`=0 are held until a tick samples `lineRxMr`=0. At that tick `lineTxMx` returns to 1 and `lineTxByte` returns to 8'hFF.
- R5: `txReady` is 1 only when no byte is pending or in flight. A byte is taken on a cycle with `txValid` and `txReady` both high, and `txReady` then stays 0 until the transfer ends.
- R6: A tick that samples `lineRxMx`=0 after the previous tick sampled it 1 captures `lineRxByte`. The captured byte appears on `rxByte` with a one-cycle `rxValid` pulse in the cycle after the tick, and `lineTxMr` is 0 for exactly the following frame. If `lineRxMx` stays low, nothing more is captured.
- R7: `rxByte` reads 8'hFF once IDLE_FRAMES consecutive ticks have sampled `lineRxMx`=1 and `lineTxMr`=1. Otherwise it reads the last captured byte.
- R8: A `txAbort` pulse takes effect at the next tick: `lineTxMx`=1, `lineTxByte`=8'hFF, `txReady`=1. Any pending byte is discarded and never sent.
- R9: Receive capture and acknowledge work while a transmit is in flight, without disturbing the transmit byte or MX. In loopback every byte value 0..255 is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-cycle pulse per frame boundary |
| txByte | input | 8 | Byte to transmit |
| txValid | input | 1 | txByte is offered |
| txReady | output | 1 | Block can take a byte |
| txAbort | input | 1 | Abort the current transmit at the next tick |
| rxByte | output | 8 | Last received byte, 8'hFF while the receive direction is idle |
| rxValid | output | 1 | One-cycle strobe for a newly captured byte |
| lineRxByte | input | 8 | Far end's monitor byte for the frame just ended |
| lineRxMx | input | 1 | Far end's transmit flag, active low |
| lineRxMr | input | 1 | Far end's acknowledge flag, active low |
| lineTxByte | output | 8 | Monitor byte driven for the coming frame |
| lineTxMx | output | 1 | Own transmit flag, active low |
| lineTxMr | output | 1 | Own acknowledge flag, active low |

## Verification
The hardest situation to reach from the ports is a quiet-count restart in the middle of a wait: the far end's MR has to dip for exactly one frame while a byte is pending, after the block has already counted part of the quiet window. The bench drives the far-end bits frame by frame, so it can place that one-frame dip between two ticks and then count the three further ticks the byte has to wait. A receive edge is also injected while a transmit is held, and a loopback sweep of all 256 byte values checks both halves working together.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef struct packed {
    logic loadTx;
    logic sendTx;
    logic releaseTx;
    logic captureRx;
    logic ackRx;
    logic releaseAck;
  } monStrobes_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PEND = 2'd1,
    TX_SEND = 2'd2
  } txState_t;

endpackage

// File: rtl/mon_idle_cnt.sv
module mon_idle_cnt #(
  parameter int IDLE_FRAMES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  input  logic quiet,
  output logic isIdle
);
  localparam int CNT_W = $clog2(IDLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_FRAMES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (advance) begin
      if (!quiet) begin
        cnt <= '0;
      end else if (cnt < LIMIT) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign isIdle = (cnt == LIMIT);

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIMIT);

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !quiet) |=> !isIdle);

endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
  import mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        txValid,
  input  logic        txAbort,
  input  logic        lineRxMx,
  input  logic        lineRxMr,
  input  logic        txChanIdle,
  output monStrobes_t strb,
  output logic        txReady
);
  txState_t state, nextState;
  logic     abortPend;
  logic     prevRxMx;

  always_comb begin
    strb      = '0;
    nextState = state;
    if (state == TX_IDLE && txValid) begin
      strb.loadTx = 1'b1;
      nextState   = TX_PEND;
    end
    if (frameTick) begin
      if (txAbort || abortPend) begin
        strb.releaseTx = 1'b1;
        nextState      = TX_IDLE;
      end else if (state == TX_PEND && txChanIdle) begin
        strb.sendTx = 1'b1;
        nextState   = TX_SEND;
      end else if (state == TX_SEND && !lineRxMr) begin
        strb.releaseTx = 1'b1;
        nextState      = TX_IDLE;
      end
      if (prevRxMx && !lineRxMx) begin
        strb.captureRx = 1'b1;
        strb.ackRx     = 1'b1;
      end else begin
        strb.releaseAck = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= TX_IDLE;
      abortPend <= 1'b0;
      prevRxMx  <= 1'b1;
    end else begin
      state <= nextState;
      if (frameTick) begin
        abortPend <= 1'b0;
        prevRxMx  <= lineRxMx;
      end else if (txAbort) begin
        abortPend <= 1'b1;
      end
    end
  end

  assign txReady = (state == TX_IDLE);

  // R5
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && !frameTick) |=> !txReady);

  // R8
  abort_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && abortPend) |=> txReady);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sendTx, strb.releaseTx}) && $onehot0({strb.captureRx, strb.releaseAck}));

endmodule

// File: rtl/mon_dpath.sv
module mon_dpath
  import mon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  monStrobes_t       strb,
  input  logic [DATA_W-1:0] txByte,
  input  logic [DATA_W-1:0] lineRxByte,
  input  logic              lineRxMx,
  input  logic              lineRxMr,
  output logic [DATA_W-1:0] lineTxByte,
  output logic              lineTxMx,
  output logic              lineTxMr,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              txChanIdle
);
  logic [DATA_W-1:0] holdByte;
  logic [DATA_W-1:0] rxHeld;
  logic              rxChanIdle;

  mon_idle_cnt #(.IDLE_FRAMES(IDLE_FRAMES)) u_txIdle (
    .clk    (clk),
    .rstN   (rstN),
    .advance(frameTick),
    .quiet  (lineTxMx && lineRxMr),
    .isIdle (txChanIdle)
  );

  mon_idle_cnt #(.IDLE_FRAMES(IDLE_FRAMES)) u_rxIdle (
    .clk    (clk),
    .rstN   (rstN),
    .advance(frameTick),
    .quiet  (lineRxMx && lineTxMr),
    .isIdle (rxChanIdle)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte   <= '1;
      lineTxByte <= '1;
      lineTxMx   <= 1'b1;
      lineTxMr   <= 1'b1;
      rxHeld     <= '1;
      rxValid    <= 1'b0;
    end else begin
      if (strb.loadTx) holdByte <= txByte;
      if (strb.sendTx) begin
        lineTxByte <= holdByte;
        lineTxMx   <= 1'b0;
      end else if (strb.releaseTx) begin
        lineTxByte <= '1;
        lineTxMx   <= 1'b1;
      end
      if (strb.ackRx)           lineTxMr <= 1'b0;
      else if (strb.releaseAck) lineTxMr <= 1'b1;
      if (strb.captureRx) rxHeld <= lineRxByte;
      rxValid <= strb.captureRx;
    end
  end

  assign rxByte = rxChanIdle ? '1 : rxHeld;

  // R3
  start_needs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineTxMx) |-> $past(txChanIdle));

  // R2
  frame_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> ($stable(lineTxMx) && $stable(lineTxMr) && $stable(lineTxByte)));

  // R4
  byte_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineTxMx && $past(!lineTxMx)) |-> $stable(lineTxByte));

  // R6
  ack_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !lineTxMr);

endmodule

// File: rtl/mon_handshake.sv
module mon_handshake
  import mon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txValid,
  output logic              txReady,
  input  logic              txAbort,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  input  logic [DATA_W-1:0] lineRxByte,
  input  logic              lineRxMx,
  input  logic              lineRxMr,
  output logic [DATA_W-1:0] lineTxByte,
  output logic              lineTxMx,
  output logic              lineTxMr
);
  monStrobes_t strb;
  logic        txChanIdle;

  mon_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameTick (frameTick),
    .txValid   (txValid),
    .txAbort   (txAbort),
    .lineRxMx  (lineRxMx),
    .lineRxMr  (lineRxMr),
    .txChanIdle(txChanIdle),
    .strb      (strb),
    .txReady   (txReady)
  );

  mon_dpath #(.DATA_W(DATA_W), .IDLE_FRAMES(IDLE_FRAMES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .frameTick (frameTick),
    .strb      (strb),
    .txByte    (txByte),
    .lineRxByte(lineRxByte),
    .lineRxMx  (lineRxMx),
    .lineRxMr  (lineRxMr),
    .lineTxByte(lineTxByte),
    .lineTxMx  (lineTxMx),
    .lineTxMr  (lineTxMr),
    .rxByte    (rxByte),
    .rxValid   (rxValid),
    .txChanIdle(txChanIdle)
  );

endmodule

// File: tb/mon_handshake_tb.sv
module mon_handshake_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameTick = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       txAbort = 1'b0;
  logic [7:0] rxByte;
  logic       rxValid;
  logic [7:0] lineRxByte;
  logic       lineRxMx;
  logic       lineRxMr;
  logic [7:0] lineTxByte;
  logic       lineTxMx;
  logic       lineTxMr;

  logic       loopMode = 1'b0;
  logic [7:0] mRxByte = 8'hFF;
  logic       mRxMx = 1'b1;
  logic       mRxMr = 1'b1;
  logic       sawValid, sawValidLate;
  logic [7:0] sawByte;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  assign lineRxByte = loopMode ? lineTxByte : mRxByte;
  assign lineRxMx   = loopMode ? lineTxMx   : mRxMx;
  assign lineRxMr   = loopMode ? lineTxMr   : mRxMr;

  always #5 clk = ~clk;

  mon_handshake u_dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .txByte(txByte), .txValid(txValid), .txReady(txReady), .txAbort(txAbort),
    .rxByte(rxByte), .rxValid(rxValid),
    .lineRxByte(lineRxByte), .lineRxMx(lineRxMx), .lineRxMr(lineRxMr),
    .lineTxByte(lineTxByte), .lineTxMx(lineTxMx), .lineTxMr(lineTxMr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doFrame();
    @(negedge clk) frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
    sawValid = rxValid;
    sawByte  = rxByte;
    @(negedge clk);
    sawValidLate = rxValid;
    @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk) txByte = b; txValid = 1'b1;
    @(negedge clk) txValid = 1'b0;
  endtask

  task automatic pulseAbort();
    @(negedge clk) txAbort = 1'b1;
    @(negedge clk) txAbort = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(lineTxMx == 1'b1, "R1 mx", lineTxMx, 1);
    check(lineTxMr == 1'b1, "R1 mr", lineTxMr, 1);
    check(lineTxByte == 8'hFF, "R1 txbyte", lineTxByte, 8'hFF);
    check(rxByte == 8'hFF, "R1 rxbyte", rxByte, 8'hFF);
    check(rxValid == 1'b0, "R1 rxvalid", rxValid, 0);
    check(txReady == 1'b1, "R1 ready", txReady, 1);

    // R5 / R3: accept byte, wait two quiet frames
    pushByte(8'hA5);
    check(txReady == 1'b0, "R5 ready after load", txReady, 0);
    check(lineTxMx == 1'b1, "R2 no change between ticks", lineTxMx, 1);
    doFrame();
    check(lineTxMx == 1'b1, "R3 quiet frame 1", lineTxMx, 1);
    doFrame();
    check(lineTxMx == 1'b1, "R3 quiet frame 2", lineTxMx, 1);
    doFrame();
    check(lineTxMx == 1'b0, "R3 send mx", lineTxMx, 0);
    check(lineTxByte == 8'hA5, "R3 send byte", lineTxByte, 8'hA5);

    // R4 hold, R9 receive during transmit
    doFrame();
    check(lineTxMx == 1'b0 && lineTxByte == 8'hA5, "R4 hold", {lineTxMx, lineTxByte}, 9'h0A5);
    mRxByte = 8'hC3; mRxMx = 1'b0;
    doFrame();
    check(sawValid && sawByte == 8'hC3, "R9 rx while tx", {sawValid, sawByte}, 9'h1C3);
    check(lineTxMr == 1'b0, "R9 ack while tx", lineTxMr, 0);
    check(lineTxMx == 1'b0 && lineTxByte == 8'hA5, "R9 tx undisturbed", {lineTxMx, lineTxByte}, 9'h0A5);
    mRxMx = 1'b1;
    doFrame();
    check(lineTxMr == 1'b1, "R6 ack one frame", lineTxMr, 1);
    check(lineTxMx == 1'b0, "R4 still held", lineTxMx, 0);
    mRxMr = 1'b0;
    doFrame();
    check(lineTxMx == 1'b1 && lineTxByte == 8'hFF, "R4 release", {lineTxMx, lineTxByte}, 9'h1FF);
    check(txReady == 1'b1, "R5 ready after ack", txReady, 1);

    // R3 quiet count restart
    pushByte(8'h3C);
    mRxMr = 1'b1;
    doFrame();
    check(lineTxMx == 1'b1, "R3 count 1", lineTxMx, 1);
    mRxMr = 1'b0;
    doFrame();
    check(lineTxMx == 1'b1, "R3 restart", lineTxMx, 1);
    mRxMr = 1'b1;
    doFrame();
    check(lineTxMx == 1'b1, "R3 recount 1", lineTxMx, 1);
    doFrame();
    check(lineTxMx == 1'b1, "R3 recount 2", lineTxMx, 1);
    doFrame();
    check(lineTxMx == 1'b0 && lineTxByte == 8'h3C, "R3 send after restart", {lineTxMx, lineTxByte}, 9'h03C);

    // R8 abort while sending
    pulseAbort();
    check(lineTxMx == 1'b0, "R2 abort waits for tick", lineTxMx, 0);
    doFrame();
    check(lineTxMx == 1'b1 && lineTxByte == 8'hFF, "R8 abort send", {lineTxMx, lineTxByte}, 9'h1FF);
    check(txReady == 1'b1, "R8 ready", txReady, 1);
    // R8 abort while pending
    pushByte(8'h77);
    pulseAbort();
    doFrame();
    check(txReady == 1'b1, "R8 pend dropped ready", txReady, 1);
    for (int i = 0; i < 4; i++) begin
      doFrame();
      check(lineTxMx == 1'b1 && lineTxByte == 8'hFF, "R8 never sent", {lineTxMx, lineTxByte}, 9'h1FF);
    end

    // R7 / R6 receive path
    check(rxByte == 8'hFF, "R7 idle reads FF", rxByte, 8'hFF);
    mRxByte = 8'h5A; mRxMx = 1'b0;
    doFrame();
    check(sawValid && sawByte == 8'h5A, "R6 capture", {sawValid, sawByte}, 9'h15A);
    check(sawValidLate == 1'b0, "R6 one-cycle strobe", sawValidLate, 0);
    check(lineTxMr == 1'b0, "R6 ack low", lineTxMr, 0);
    mRxByte = 8'h11;
    doFrame();
    check(!sawValid, "R6 no recapture", sawValid, 0);
    check(lineTxMr == 1'b1 && rxByte == 8'h5A, "R6 ack released", {lineTxMr, rxByte}, 9'h15A);
    mRxMx = 1'b1;
    doFrame();
    check(rxByte == 8'h5A, "R7 one quiet frame", rxByte, 8'h5A);
    doFrame();
    check(rxByte == 8'hFF, "R7 two quiet frames", rxByte, 8'hFF);

    // R9 loopback sweep
    loopMode = 1'b1;
    for (int b = 0; b < 256; b++) begin
      int guard;
      bit got;
      logic [7:0] gotByte;
      guard = 0;
      while (!txReady && guard < 10) begin doFrame(); guard++; end
      pushByte(8'(b));
      got = 1'b0;
      gotByte = 8'h00;
      for (int f = 0; f < 10 && !got; f++) begin
        doFrame();
        if (sawValid) begin got = 1'b1; gotByte = sawByte; end
      end
      check(got && gotByte == 8'(b), "R9 loopback", {got, gotByte}, {1'b1, 8'(b)});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule